// File: doc/BRIEF.md
# Carrier Presence Qualifier with Time Hysteresis

This block decides whether a usable FSK carrier is on the line. A demodulator upstream presents a tone-ok flag, one bit per clock, that says whether the current samples look like an in-band tone. The qualifier lowers an active-low carrier flag only after that tone has been present without a break for a set time. It raises the flag again only after the tone has been absent for a second, shorter time. Because the two timers differ, a short dropout in the tone does not make the flag toggle.

All timing comes from a millisecond tick. A prescaler divides the system clock down to this tick, and both timers count ticks. An active-high copy of the qualified state drives the data-release input of the demodulator. That input keeps the serial data output parked high until a carrier has been accepted. A power-down input forces the flag to its released (high) state, clears every counter, and makes the block ignore the tone-ok flag for as long as it stays high.

Top module: `cdq_carrier_qual`

## Requirements
- R1: After reset, carrier_n is 1 and data_release is 0.
- R2: Tick pulses fire every TICK_DIV clocks, counted from reset or from the end of power-down. While carrier_n is 1, carrier_n goes to 0 on the clock edge that registers the ASSERT_TICKS-th tick during which tone_ok has stayed 1 without a break.
- R3: If tone_ok drops to 0 before the assert time has run out, the assert count restarts from zero. carrier_n stays 1.
- R4: While carrier_n is 0, carrier_n returns to 1 on the clock edge that registers the RELEASE_TICKS-th tick during which tone_ok has stayed 0 without a break.
- R5: If tone_ok returns to 1 before the release time has run out, carrier_n stays 0 and the release count restarts from zero.
- R6: While pwdn is 1, carrier_n is 1 from the next clock edge on, and tone_ok has no effect. The prescaler and both timers restart from zero once pwdn returns to 0.
- R7: data_release is always the inverse of carrier_n.
- R8: ASSERT_TICKS and RELEASE_TICKS are derived from millisecond parameters (10 ms and 8 ms by default), and each one is at least one tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pwdn | input | 1 | Power-down: releases the flag and clears the timers |
| tone_ok | input | 1 | Per-clock in-band tone flag from the demodulator |
| carrier_n | output | 1 | Qualified carrier present, active low |
| data_release | output | 1 | Active-high qualification that unlocks the demodulator data output |

## Verification
The assertions assume that tone_ok and pwdn are synchronous to clk and change only between edges. They also assume that the minimum-persistence check can measure a tone run with an unbroken count of cycles in which pwdn is 0. The bench drives every input on the falling edge so that it meets this assumption. It uses random runs of tone and gap whose lengths lie on both sides of the assert and release windows, and it adds occasional power-down pulses. Each run is checked cycle by cycle against a timing model computed in the bench.

// File: rtl/cdq_pkg.sv
package cdq_pkg;

    typedef enum logic {
        CDQ_IDLE = 1'b0,
        CDQ_LOCK = 1'b1
    } cdq_state_e;

    typedef struct packed {
        cdq_state_e state;
    } cdq_regs_t;

    function automatic int unsigned cdq_ms_to_ticks(input int unsigned ms);
        return (ms == 0) ? 1 : ms;
    endfunction

endpackage

// File: rtl/cdq_tick_gen.sv
module cdq_tick_gen #(
    parameter int unsigned DIV = 3580
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);
    localparam int unsigned CW = (DIV > 2) ? $clog2(DIV) : 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tick_regs_t;

    tick_regs_t r_d, r_q;
    logic       wrap;

    always_comb begin
        r_d  = r_q;
        wrap = (r_q.cnt == CW'(DIV - 1));
        if (clr) begin
            r_d.cnt = '0;
        end else if (wrap) begin
            r_d.cnt = '0;
        end else begin
            r_d.cnt = r_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign tick = wrap && !clr;

endmodule

// File: rtl/cdq_persist_timer.sv
module cdq_persist_timer #(
    parameter int unsigned LIMIT = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic arm,
    input  logic tick,
    output logic done
);
    localparam int unsigned CW = (LIMIT > 1) ? $clog2(LIMIT + 1) : 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
    } pt_regs_t;

    pt_regs_t r_d, r_q;
    logic     last;

    always_comb begin
        r_d  = r_q;
        last = (r_q.cnt == CW'(LIMIT - 1));
        done = 1'b0;
        if (clr || !arm) begin
            r_d.cnt = '0;
        end else if (tick) begin
            if (last) begin
                done    = 1'b1;
                r_d.cnt = '0;
            end else begin
                r_d.cnt = r_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

endmodule

// File: rtl/cdq_carrier_qual.sv
module cdq_carrier_qual
    import cdq_pkg::*;
#(
    parameter int unsigned CLK_HZ     = 3579545,
    parameter int unsigned TICK_HZ    = 1000,
    parameter int unsigned ASSERT_MS  = 10,
    parameter int unsigned RELEASE_MS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwdn,
    input  logic tone_ok,
    output logic carrier_n,
    output logic data_release
);
    localparam int unsigned TICK_DIV      = (CLK_HZ + TICK_HZ / 2) / TICK_HZ;
    localparam int unsigned ASSERT_TICKS  = cdq_ms_to_ticks(ASSERT_MS);
    localparam int unsigned RELEASE_TICKS = cdq_ms_to_ticks(RELEASE_MS);

    cdq_regs_t r_d, r_q;
    logic      tick;
    logic      arm_on, arm_off;
    logic      on_done, off_done;

    cdq_tick_gen #(.DIV(TICK_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (pwdn),
        .tick  (tick)
    );

    assign arm_on  = (r_q.state == CDQ_IDLE) &&  tone_ok;
    assign arm_off = (r_q.state == CDQ_LOCK) && !tone_ok;

    cdq_persist_timer #(.LIMIT(ASSERT_TICKS)) u_on_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (pwdn),
        .arm   (arm_on),
        .tick  (tick),
        .done  (on_done)
    );

    cdq_persist_timer #(.LIMIT(RELEASE_TICKS)) u_off_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (pwdn),
        .arm   (arm_off),
        .tick  (tick),
        .done  (off_done)
    );

    always_comb begin
        r_d = r_q;
        if (pwdn) begin
            r_d.state = CDQ_IDLE;
        end else begin
            unique case (r_q.state)
                CDQ_IDLE: if (on_done)  r_d.state = CDQ_LOCK;
                CDQ_LOCK: if (off_done) r_d.state = CDQ_IDLE;
                default:                r_d.state = CDQ_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state <= CDQ_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign carrier_n    = (r_q.state != CDQ_LOCK);
    assign data_release = (r_q.state == CDQ_LOCK);

endmodule

// File: rtl/cdq_carrier_qual_chk.sv
module cdq_carrier_qual_chk #(
    parameter int unsigned TICK_DIV     = 4,
    parameter int unsigned ASSERT_TICKS = 2
) (
    input logic clk,
    input logic rst_n,
    input logic pwdn,
    input logic tone_ok,
    input logic carrier_n,
    input logic data_release
);
    localparam int unsigned MIN_RUN = (ASSERT_TICKS - 1) * TICK_DIV + 1;

    logic [31:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (pwdn || !tone_ok) begin
            run_q <= '0;
        end else if (run_q != 32'hFFFF_FFFF) begin
            run_q <= run_q + 1'b1;
        end
    end

    assert_inverse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        data_release == !carrier_n);

    assert_pwdn_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pwdn |=> carrier_n);

    assert_fall_needs_tone_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(carrier_n) |-> ($past(tone_ok) && !$past(pwdn)));

    assert_rise_needs_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(carrier_n) && !$past(pwdn)) |-> !$past(tone_ok));

    assert_min_persist_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(carrier_n) |-> (run_q >= MIN_RUN));

endmodule

bind cdq_carrier_qual cdq_carrier_qual_chk #(
    .TICK_DIV     (TICK_DIV),
    .ASSERT_TICKS (ASSERT_TICKS)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .pwdn         (pwdn),
    .tone_ok      (tone_ok),
    .carrier_n    (carrier_n),
    .data_release (data_release)
);

// File: tb/cdq_carrier_qual_test.sv
module cdq_carrier_qual_test;
    localparam int DIV = 4;
    localparam int AT  = 5;
    localparam int RT  = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwdn = 1'b0;
    logic tone_ok = 1'b0;
    logic carrier_n, data_release;

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;
    string phase = "R1";

    always #5 clk = ~clk;

    cdq_carrier_qual #(
        .CLK_HZ(DIV), .TICK_HZ(1), .ASSERT_MS(AT), .RELEASE_MS(RT)
    ) uut (
        .clk(clk), .rst_n(rst_n), .pwdn(pwdn), .tone_ok(tone_ok),
        .carrier_n(carrier_n), .data_release(data_release)
    );

    // Bench timing model built from R2..R6
    int m_pre, m_cnt;
    bit m_on;
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n || pwdn) begin
            m_pre <= 0; m_cnt <= 0; m_on <= 1'b0;
        end else begin
            automatic bit tk = (m_pre == DIV - 1);
            m_pre <= tk ? 0 : m_pre + 1;
            if (!m_on) begin
                if (!tone_ok) m_cnt <= 0;
                else if (tk) begin
                    if (m_cnt + 1 >= AT) begin m_on <= 1'b1; m_cnt <= 0; end
                    else m_cnt <= m_cnt + 1;
                end
            end else begin
                if (tone_ok) m_cnt <= 0;
                else if (tk) begin
                    if (m_cnt + 1 >= RT) begin m_on <= 1'b0; m_cnt <= 0; end
                    else m_cnt <= m_cnt + 1;
                end
            end
        end
    end

    function automatic bit exp_cn();
        return !m_on;
    endfunction

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model, sampled on the falling edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            check(phase, carrier_n, exp_cn());
            check("R7", data_release, ~carrier_n);
        end
    end

    task automatic drive(input logic t, input int n);
        tone_ok = t;
        repeat (n) @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        check("R1", carrier_n, 1'b1);
        check("R1", data_release, 1'b0);
        rst_n = 1'b1;

        // R2: long tone locks; R8 assert window of AT ticks
        phase = "R2";
        drive(1'b1, AT * DIV + 8);
        check("R2", carrier_n, 1'b0);
        // R5: short gap under release time keeps lock
        phase = "R5";
        drive(1'b0, (RT - 1) * DIV - 1);
        drive(1'b1, 3);
        check("R5", carrier_n, 1'b0);
        // R4: long gap releases
        phase = "R4";
        drive(1'b0, RT * DIV + 6);
        check("R4", carrier_n, 1'b1);
        // R3: tone broken just short of assert time
        phase = "R3";
        drive(1'b1, (AT - 1) * DIV);
        drive(1'b0, 1);
        drive(1'b1, (AT - 1) * DIV - 1);
        check("R3", carrier_n, 1'b1);
        drive(1'b0, 2);
        // R6: power-down masks tone
        phase = "R6";
        pwdn = 1'b1;
        drive(1'b1, AT * DIV * 3);
        check("R6", carrier_n, 1'b1);
        pwdn = 1'b0;
        drive(1'b1, AT * DIV + 4);
        check("R6", carrier_n, 1'b0);
        pwdn = 1'b1;
        drive(1'b1, 2);
        check("R6", carrier_n, 1'b1);
        pwdn = 1'b0;
        drive(1'b0, 4);

        // random runs around both windows
        phase = "R2 R3 R4 R5 R6 R8";
        for (int i = 0; i < 600; i++) begin
            automatic int len = 1 + int'($urandom_range(0, (AT + 1) * DIV));
            if ($urandom_range(0, 19) == 0) pwdn = 1'b1;
            drive(logic'($urandom_range(0, 1)), len);
            pwdn = 1'b0;
        end

        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule